// File: doc/BRIEF.md
# Reaction Time Tester

This block runs a reaction-time game from three push buttons. A press of start arms a fixed waiting period; when that period ends an LED lights, and a decimal stopwatch begins counting in hundredths of a second. A press of stop turns the LED off and freezes the count. The count stays on a bank of seven-segment digits until reset. Reset returns everything to the idle state and shows zero on every digit.

Inside the block there is a four-state controller and a delay counter that times the pre-stimulus wait. A divider makes one pulse every hundredth of a second. A chain of decimal digit stages counts these pulses, and each stage passes a carry to the next when it rolls over from nine. A registered decoder drives the segment lines. With the default 50 MHz clock, the wait is 200,000,000 cycles and a hundredth of a second is 500,000 cycles. The display has four digits. The buttons are expected to be debounced and synchronised before they reach the block. Each digit has its own segment lines, so there is no display multiplexing.

Top module: `rt_reaction_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `led_o` is 0 and every digit shows the pattern for 0. The controller is idle.
- R2: A start press sampled while idle lights `led_o` exactly DELAY_CYCLES clock edges after the edge that sampled it.
- R3: While the LED is lit, the count rises by one every TICK_CYCLES cycles. Suppose stop is sampled m edges after the LED edge. The frozen count is then floor((m-1)/TICK_CYCLES): a tick that falls on the stop edge is dropped. Digit k, with k=0 least significant, drives `seg_o[7k+6:7k]`. The display follows the count one cycle later.
- R4: Stop and start presses during the waiting period have no effect. The LED still lights on schedule, and the result is the same as if they had not happened.
- R5: A stop press while the LED is lit clears `led_o` on that same edge. From then on the count and the display do not change until reset.
- R6: Start presses are ignored while the LED is lit and while a result is held. The LED stays as it was, and the count is not disturbed.
- R7: The count saturates at all nines (9999 with four digits). It never wraps to zero.
- R8: Segment lines are active-low, with bit 0 driving segment a up to bit 6 driving segment g. In active-low hex (g..a), digits 0 to 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00, 10.
- R9: Each digit holds a value from 0 to 9. A digit steps past 9 back to 0 and carries one into the next digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Start press, one cycle or longer, synchronised |
| stop_btn | input | 1 | Stop press, synchronised |
| led_o | output | 1 | Stimulus LED, registered |
| seg_o | output | DIGITS*7 | Active-low segment lines, seven per digit, digit 0 lowest |

## Verification
The bench builds the block with two digits, a three-cycle tick and a twenty-cycle delay. With these values every count from 0 to 99, every carry between the digits, and the saturation point can be reached in a few hundred cycles per trial. Every stop offset from 1 to 305 cycles after the LED edge is swept, so every phase of the stop press against the tick is covered. The expected frozen count is computed as floor((m-1)/3), capped at 99. Each trial also injects stray start and stop presses while waiting, and a stray start while lit and while holding a result.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LIT   = 2'd2,
    ST_HELD  = 2'd3
  } rt_state_e;

  // active-low segments, bit0 = a ... bit6 = g; blank for non-decimal codes
  function automatic logic [6:0] seg_encode(input logic [3:0] d);
    logic [6:0] on;
    case (d)
      4'd0: on = 7'b0111111;
      4'd1: on = 7'b0000110;
      4'd2: on = 7'b1011011;
      4'd3: on = 7'b1001111;
      4'd4: on = 7'b1100110;
      4'd5: on = 7'b1101101;
      4'd6: on = 7'b1111101;
      4'd7: on = 7'b0000111;
      4'd8: on = 7'b1111111;
      4'd9: on = 7'b1101111;
      default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction

endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
  parameter int PERIOD = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

  generate
    if (PERIOD > 1) begin : g_gap
      // R3: ticks are isolated pulses, one per period
      p_tick_isolated_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rt_bcd_stage.sv
module rt_bcd_stage (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc_i,
  output logic [3:0] digit_o,
  output logic       carry_o
);
  always_ff @(posedge clk) begin
    if (rst)                 digit_o <= 4'd0;
    else if (inc_i)          digit_o <= (digit_o == 4'd9) ? 4'd0 : digit_o + 4'd1;
  end

  assign carry_o = inc_i && (digit_o == 4'd9);

  p_digit_range_r9: assert property (@(posedge clk) disable iff (rst)
    digit_o <= 4'd9);
  p_roll_to_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (inc_i && digit_o == 4'd9) |=> digit_o == 4'd0);
endmodule

// File: rtl/rt_seg_bank.sv
module rt_seg_bank #(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIGITS*4-1:0]   digits_i,
  output logic [DIGITS*7-1:0]   seg_o
);
  import rt_pkg::*;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    always_ff @(posedge clk) begin
      if (rst) seg_o[k*7 +: 7] <= seg_encode(4'd0);
      else     seg_o[k*7 +: 7] <= seg_encode(digits_i[k*4 +: 4]);
    end
  end
endmodule

// File: rtl/rt_reaction_timer.sv
module rt_reaction_timer #(
  parameter int DIGITS       = 4,
  parameter int TICK_CYCLES  = 500000,
  parameter int DELAY_CYCLES = 200000000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_btn,
  input  logic                stop_btn,
  output logic                led_o,
  output logic [DIGITS*7-1:0] seg_o
);
  import rt_pkg::*;

  localparam int DW = DIGITS * 4;

  rt_state_e        state, nxt;
  logic             delay_done, hund_tick, all_nine, count_en;
  logic [DW-1:0]    digits;
  logic [DIGITS:0]  carry;

  // delay counter: runs only while armed
  rt_tick_gen #(.PERIOD(DELAY_CYCLES)) u_delay (
    .clk(clk), .rst(rst), .en(state == ST_ARMED), .tick(delay_done));

  // hundredth-second tick: phase restarts when the LED lights
  rt_tick_gen #(.PERIOD(TICK_CYCLES)) u_hund (
    .clk(clk), .rst(rst), .en(state == ST_LIT), .tick(hund_tick));

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start_btn)  nxt = ST_ARMED;
      ST_ARMED: if (delay_done) nxt = ST_LIT;
      ST_LIT:   if (stop_btn)   nxt = ST_HELD;
      default:                  nxt = ST_HELD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      led_o <= 1'b0;
    end else begin
      state <= nxt;
      led_o <= (nxt == ST_LIT);
    end
  end

  always_comb begin
    all_nine = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      all_nine &= (digits[k*4 +: 4] == 4'd9);
  end

  assign count_en = (state == ST_LIT) && hund_tick && !stop_btn && !all_nine;
  assign carry[0] = count_en;

  for (genvar k = 0; k < DIGITS; k++) begin : g_stage
    rt_bcd_stage u_stage (
      .clk(clk), .rst(rst), .inc_i(carry[k]),
      .digit_o(digits[k*4 +: 4]), .carry_o(carry[k+1]));
  end

  rt_seg_bank #(.DIGITS(DIGITS)) u_seg (
    .clk(clk), .rst(rst), .digits_i(digits), .seg_o(seg_o));

  // R2: the LED can only light at the end of the waiting period
  p_led_from_wait_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(led_o) |-> $past(state) == ST_ARMED);
  // R4: stop is not acted on while waiting
  p_wait_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && !delay_done) |=> state == ST_ARMED);
  // R5: a held result never moves
  p_held_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    state == ST_HELD |=> (state == ST_HELD && $stable(digits) && !led_o));
  // R6: start while lit leaves the LED on unless stop is pressed
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LIT && !stop_btn) |=> led_o);
  // R7: no wrap once every digit reads nine
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    all_nine |=> $stable(digits));
endmodule

// File: tb/sim_rt_reaction_timer.sv
module sim_rt_reaction_timer;
  localparam int DIGITS = 2;
  localparam int TICK   = 3;
  localparam int DELAY  = 20;
  localparam int MAXC   = 99;

  logic clk = 1'b0, rst = 1'b1, start_btn = 1'b0, stop_btn = 1'b0;
  logic led_o;
  logic [DIGITS*7-1:0] seg_o;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  rt_reaction_timer #(.DIGITS(DIGITS), .TICK_CYCLES(TICK), .DELAY_CYCLES(DELAY)) u0 (
    .clk(clk), .rst(rst), .start_btn(start_btn), .stop_btn(stop_btn),
    .led_o(led_o), .seg_o(seg_o));

  function automatic logic [6:0] exp_digit(input int d);
    logic [6:0] lo;
    case (d)
      0: lo = 7'h40; 1: lo = 7'h79; 2: lo = 7'h24; 3: lo = 7'h30; 4: lo = 7'h19;
      5: lo = 7'h12; 6: lo = 7'h02; 7: lo = 7'h78; 8: lo = 7'h00; default: lo = 7'h10;
    endcase
    return lo;
  endfunction

  function automatic logic [DIGITS*7-1:0] exp_seg(input int v);
    logic [DIGITS*7-1:0] r;
    int x = v;
    for (int k = 0; k < DIGITS; k++) begin
      r[k*7 +: 7] = exp_digit(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(led_o == 1'b0, "R1 led", led_o, 0);
    check(seg_o == exp_seg(0), "R1 R8 zero display", seg_o, exp_seg(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [DIGITS*7-1:0] held;
    int expc;
    do_reset();
    for (int m = 1; m <= 305; m++) begin
      // start sampled at edge E0
      start_btn = 1'b1;
      @(negedge clk);
      start_btn = 1'b0;
      // R4: stray stop and start while waiting
      for (int i = 0; i < DELAY - 1; i++) begin
        stop_btn  = (i == 3);
        start_btn = (i == 5);
        @(negedge clk);
      end
      stop_btn = 1'b0;
      start_btn = 1'b0;
      check(led_o == 1'b0, "R2 led early", led_o, 0);
      @(negedge clk);
      check(led_o == 1'b1, "R2 R4 led on time", led_o, 1);
      // counting phase, R6: stray start while lit
      for (int i = 1; i < m; i++) begin
        start_btn = (i == 2);
        @(negedge clk);
      end
      start_btn = 1'b0;
      check(led_o == 1'b1, "R6 led stays lit", led_o, 1);
      stop_btn = 1'b1;
      @(negedge clk);
      stop_btn = 1'b0;
      check(led_o == 1'b0, "R5 led off at stop", led_o, 0);
      @(negedge clk);
      expc = (m - 1) / TICK;
      if (expc > MAXC) expc = MAXC;
      // R3 R8 R9: frozen count as decimal digits
      check(seg_o == exp_seg(expc), (expc == MAXC) ? "R7 saturated" : "R3 count", seg_o, exp_seg(expc));
      held = seg_o;
      start_btn = 1'b1;
      @(negedge clk);
      start_btn = 1'b0;
      repeat (2 * TICK + 2) @(negedge clk);
      check(seg_o == held, "R5 R6 result frozen", seg_o, held);
      check(led_o == 1'b0, "R6 led stays off", led_o, 0);
      do_reset();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule